// File: doc/BRIEF.md
# Hall Commutation Decoder with Direction Control

This block converts three digitised Hall sensor levels and a direction input into gate enables for a three-phase bridge. The bridge has one upper (source) and one lower (sink) switch per phase. For every valid rotor position it enables exactly one upper switch and one lower switch. Reverse rotation is produced by complementing the Hall code before decoding, so both directions use the same six source/sink pairs.

The upper switch of the active pair stays fully on. Only the lower switch is chopped by the PWM duty input. Other conditions also turn the lower switch off: a peak-current flag, which keeps it off until the next PWM period starts, and a lock-protection fault. A run/stop input turns every switch off. Any change of the effective rotor code, whether from a Hall edge or a direction change, opens a dead-time gap in which all six switches are off. The gap prevents shoot-through when the drive pair changes.

All outputs are registered. Each output reflects the inputs sampled at the clock edge that produces it.

Top module: `hall_commutator`

## Requirements
- R1: Forward decode. With `dir`=0 the effective code is `hall` itself, where `hall[2]`,`hall[1]`,`hall[0]` are sensors 1,2,3 and bit k of `hi_en`/`lo_en` is phase k+1. The code-to-pair mapping (source→sink) is: 101→2→1, 100→3→1, 110→3→2, 010→1→2, 011→1→3, 001→2→3.
- R2: Reverse decode. With `dir`=1 the effective code is the bitwise complement of `hall`, and it is decoded with the R1 mapping.
- R3: Effective codes 000 and 111 are invalid and turn all six enables off.
- R4: Dead time. Outputs appear one clock after the inputs are sampled. When the effective code sampled at an edge differs from the code at the previous edge, all six enables are 0 for `dead_len`+1 consecutive edges, starting at that edge. The new pair appears at the following edge. After reset the stored previous code is 000.
- R5: With `run`=0 all six enables are off at the next edge.
- R6: With `fault`=1 all lower enables are off at the next edge. The upper enable is unaffected.
- R7: With `ilim`=1 the lower enables are off at the next edge. They stay off until an edge samples `pwm_start`=1 with `ilim`=0, and may turn on again at that edge.
- R8: The lower enable follows `pwm_on`. The upper enable does not depend on `pwm_on`.
- R9: While `rst_n`=0 all enables are 0.
- R10: At most one upper and at most one lower enable are active at any time, and never both switches of the same phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall | input | 3 | Digitised Hall levels, bit 2 = sensor 1 |
| dir | input | 1 | Direction, 1 = reverse (complemented code) |
| run | input | 1 | 1 = run, 0 = stop (all off) |
| fault | input | 1 | Lock-protection fault, blocks lower switches |
| ilim | input | 1 | Peak-current flag |
| pwm_on | input | 1 | PWM duty level for the lower switch |
| pwm_start | input | 1 | One-cycle pulse at the start of each PWM period |
| dead_len | input | DT_W | Dead-time length in extra clock cycles |
| hi_en | output | 3 | Upper switch enables, bit k = phase k+1 |
| lo_en | output | 3 | Lower switch enables, bit k = phase k+1 |

## Verification
The assertions assume every input is already synchronous to `clk`. They also assume `dead_len` only matters at the edge where a code change is seen. Under those assumptions the properties can compare the effective code against its value one edge earlier, and can tie each blocking input to the next edge's outputs.

The stimulus changes every input only between clock edges. It walks the Hall code along the rotation sequence for the current direction, with occasional random and invalid codes and direction flips. Hall codes are held long enough for dead-time gaps to complete. PWM periods run from a counter, and faults, current-limit flags and stops are injected at random.

// File: rtl/hall_cmt_pkg.sv
// Package: shared types for the Hall commutation decoder.
// Assumes a three-phase bridge; bit k of every phase vector is phase k+1.
package hall_cmt_pkg;
    localparam int NPH = 3;
    typedef logic [NPH-1:0] ph_vec_t;

    // Drive pair selected by one effective Hall code
    typedef struct packed {
        logic    ok;    // code is one of the six valid positions
        ph_vec_t src;   // one-hot upper switch
        ph_vec_t snk;   // one-hot lower switch
    } drv_pair_t;
endpackage

// File: rtl/hall_cmt_decode.sv
// Module: maps an effective (direction-normalised) Hall code to a drive pair.
// Assumes the code is already complemented for reverse rotation.
module hall_cmt_decode
    import hall_cmt_pkg::*;
(
    input  logic [2:0] code,
    output drv_pair_t  pair
);
    // Purpose: six valid positions to source/sink pairs, rest invalid
    always_comb begin
        pair = '{ok: 1'b0, src: '0, snk: '0};
        unique case (code)
            3'b101: pair = '{ok: 1'b1, src: 3'b010, snk: 3'b001};
            3'b100: pair = '{ok: 1'b1, src: 3'b100, snk: 3'b001};
            3'b110: pair = '{ok: 1'b1, src: 3'b100, snk: 3'b010};
            3'b010: pair = '{ok: 1'b1, src: 3'b001, snk: 3'b010};
            3'b011: pair = '{ok: 1'b1, src: 3'b001, snk: 3'b100};
            3'b001: pair = '{ok: 1'b1, src: 3'b010, snk: 3'b100};
            default: pair = '{ok: 1'b0, src: '0, snk: '0};
        endcase
    end
endmodule

// File: rtl/hall_cmt_deadtime.sv
// Module: detects a change of the effective code and holds a gap flag
// for the change cycle plus dead_len further cycles.
// Assumes code is synchronous to clk.
module hall_cmt_deadtime #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      code,
    input  logic [DT_W-1:0] dead_len,
    output logic            gap
);
    logic [2:0]      prev_code;
    logic [DT_W-1:0] remain;
    logic            changed;

    assign changed = (code != prev_code);
    assign gap     = changed || (remain != '0);

    // Purpose: remember last code and count down the dead-time window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_code <= 3'b000;
            remain    <= '0;
        end else begin
            prev_code <= code;
            if (changed)
                remain <= dead_len;
            else if (remain != '0)
                remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/hall_cmt_chop.sv
// Module: peak-current latch. A limit flag blocks the lower switch until
// the next PWM period start that arrives without the flag.
// Assumes pwm_start is a one-cycle pulse per PWM period.
module hall_cmt_chop (
    input  logic clk,
    input  logic rst_n,
    input  logic ilim,
    input  logic pwm_start,
    output logic block
);
    logic held;

    assign block = ilim || (held && !pwm_start);

    // Purpose: set on limit flag, clear at a period start
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= 1'b0;
        else if (ilim)
            held <= 1'b1;
        else if (pwm_start)
            held <= 1'b0;
    end
endmodule

// File: rtl/hall_commutator.sv
// Module: top of the Hall commutation decoder. Normalises the Hall code for
// direction, decodes the drive pair, applies dead time, stop, fault,
// current limit and PWM chopping (lower side only), and registers the enables.
// Assumes all inputs are synchronous to clk.
module hall_commutator
    import hall_cmt_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      hall,
    input  logic            dir,
    input  logic            run,
    input  logic            fault,
    input  logic            ilim,
    input  logic            pwm_on,
    input  logic            pwm_start,
    input  logic [DT_W-1:0] dead_len,
    output logic [NPH-1:0]  hi_en,
    output logic [NPH-1:0]  lo_en
);
    logic [2:0] eff_code;
    drv_pair_t  pair;
    logic       gap;
    logic       block;
    logic       hi_ok;
    logic       lo_ok;
    ph_vec_t    hi_nxt;
    ph_vec_t    lo_nxt;

    assign eff_code = hall ^ {3{dir}};

    hall_cmt_decode u_dec (
        .code (eff_code),
        .pair (pair)
    );

    hall_cmt_deadtime #(.DT_W(DT_W)) u_dt (
        .clk      (clk),
        .rst_n    (rst_n),
        .code     (eff_code),
        .dead_len (dead_len),
        .gap      (gap)
    );

    hall_cmt_chop u_chop (
        .clk       (clk),
        .rst_n     (rst_n),
        .ilim      (ilim),
        .pwm_start (pwm_start),
        .block     (block)
    );

    // Purpose: qualify upper and lower enables
    always_comb begin
        hi_ok  = pair.ok && run && !gap;
        lo_ok  = hi_ok && !fault && pwm_on && !block;
        hi_nxt = pair.src & {NPH{hi_ok}};
        lo_nxt = pair.snk & {NPH{lo_ok}};
    end

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        // Purpose: register the two gate enables of one phase
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_en[g] <= 1'b0;
                lo_en[g] <= 1'b0;
            end else begin
                hi_en[g] <= hi_nxt[g];
                lo_en[g] <= lo_nxt[g];
            end
        end
    end
endmodule

// File: rtl/hall_commutator_chk.sv
// Module: property checker for hall_commutator, bound to every instance.
// Assumes inputs synchronous to clk.
module hall_commutator_chk #(
    parameter int DT_W = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hall,
    input logic       dir,
    input logic       run,
    input logic       fault,
    input logic       ilim,
    input logic       pwm_on,
    input logic [2:0] hi_en,
    input logic [2:0] lo_en
);
    logic [2:0] eff;
    assign eff = hall ^ {3{dir}};

    a_r10_single_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hi_en) && $onehot0(lo_en));

    a_r10_no_leg_short: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en & lo_en) == 3'b000);

    a_r5_stop_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (hi_en == 3'b000 && lo_en == 3'b000));

    a_r6_fault_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> lo_en == 3'b000);

    a_r7_limit_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        ilim |=> lo_en == 3'b000);

    a_r8_chop_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_on |=> lo_en == 3'b000);

    a_r3_invalid_off: assert property (@(posedge clk) disable iff (!rst_n)
        (eff == 3'b000 || eff == 3'b111) |=> (hi_en == 3'b000 && lo_en == 3'b000));

    a_r4_change_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (eff != $past(eff)) |=> (hi_en == 3'b000 && lo_en == 3'b000));
endmodule

bind hall_commutator hall_commutator_chk #(.DT_W(DT_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .hall   (hall),
    .dir    (dir),
    .run    (run),
    .fault  (fault),
    .ilim   (ilim),
    .pwm_on (pwm_on),
    .hi_en  (hi_en),
    .lo_en  (lo_en)
);

// File: tb/hall_commutator_tb_top.sv
// Bench: directed corners plus seeded random stimulus, checked every cycle
// against a cycle model built from the requirements.
module hall_commutator_tb_top;
    localparam int DT_W = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [2:0]      hall;
    logic            dir, run, fault, ilim, pwm_on, pwm_start;
    logic [DT_W-1:0] dead_len;
    logic [2:0]      hi_en, lo_en;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [2:0]      m_prev;
    logic [DT_W-1:0] m_cnt;
    logic            m_lat;
    logic [2:0]      eh, el;
    string           tag;

    logic [2:0] fwd_seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};

    always #10 clk = ~clk;

    hall_commutator #(.DT_W(DT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .hall(hall), .dir(dir), .run(run),
        .fault(fault), .ilim(ilim), .pwm_on(pwm_on), .pwm_start(pwm_start),
        .dead_len(dead_len), .hi_en(hi_en), .lo_en(lo_en)
    );

    // R1/R2 mapping of an effective code to {src, snk}
    function automatic logic [5:0] tb_pair(input logic [2:0] c);
        case (c)
            3'b101: return {3'b010, 3'b001};
            3'b100: return {3'b100, 3'b001};
            3'b110: return {3'b100, 3'b010};
            3'b010: return {3'b001, 3'b010};
            3'b011: return {3'b001, 3'b100};
            3'b001: return {3'b010, 3'b100};
            default: return 6'b0;
        endcase
    endfunction

    task automatic check(input string t, input logic [2:0] xh, input logic [2:0] xl);
        checks++;
        if (hi_en !== xh || lo_en !== xl) begin
            fails++;
            $display("FAIL %s hi_en=%b lo_en=%b expected hi_en=%b lo_en=%b",
                     t, hi_en, lo_en, xh, xl);
        end
    endtask

    // apply inputs, advance one edge, model it, check away from the edge
    task automatic step(input logic [2:0] h, input logic d, input logic r,
                        input logic f, input logic il, input logic pw,
                        input logic ps);
        logic [2:0] c;
        logic [5:0] pr;
        logic       g, blk, valid;
        hall = h; dir = d; run = r; fault = f; ilim = il; pwm_on = pw; pwm_start = ps;
        @(posedge clk);
        c     = h ^ {3{d}};
        pr    = tb_pair(c);
        valid = (c != 3'b000 && c != 3'b111);
        g     = (c != m_prev) || (m_cnt != '0);
        blk   = il || (m_lat && !ps);
        eh    = (valid && r && !g) ? pr[5:3] : 3'b000;
        el    = (valid && r && !g && !f && pw && !blk) ? pr[2:0] : 3'b000;
        if (!valid)      tag = "R3";
        else if (g)      tag = "R4";
        else if (!r)     tag = "R5";
        else if (f)      tag = "R6";
        else if (blk)    tag = "R7";
        else if (!pw)    tag = "R8";
        else if (d)      tag = "R2";
        else             tag = "R1";
        if (c != m_prev)      m_cnt = dead_len;
        else if (m_cnt != '0) m_cnt = m_cnt - 1'b1;
        m_prev = c;
        if (il)      m_lat = 1'b1;
        else if (ps) m_lat = 1'b0;
        #5;
        check(tag, eh, el);
    endtask

    // watchdog
    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL R4 watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int idx, hold, ph;
        logic d;
        void'($urandom(32'd4711));
        hall = 3'b101; dir = 0; run = 1; fault = 0; ilim = 0;
        pwm_on = 1; pwm_start = 0; dead_len = 4'd2;
        rst_n = 0;
        m_prev = 3'b000; m_cnt = '0; m_lat = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        check("R9", 3'b000, 3'b000);
        rst_n = 1;

        // R1: forward walk with full duty
        for (int i = 0; i < 6; i++)
            repeat (6) step(fwd_seq[i], 0, 1, 0, 0, 1, 0);
        // R2: reverse walk, complemented codes
        for (int i = 0; i < 6; i++)
            repeat (6) step(~fwd_seq[i], 1, 1, 0, 0, 1, 0);
        // R3: invalid codes in both directions
        repeat (4) step(3'b000, 0, 1, 0, 0, 1, 0);
        repeat (4) step(3'b111, 0, 1, 0, 0, 1, 0);
        repeat (4) step(3'b111, 1, 1, 0, 0, 1, 0);
        // R4: longer dead time
        dead_len = 4'd7;
        repeat (10) step(3'b110, 0, 1, 0, 0, 1, 0);
        dead_len = 4'd0;
        repeat (3) step(3'b010, 0, 1, 0, 0, 1, 0);
        dead_len = 4'd2;
        // R5: stop
        repeat (3) step(3'b010, 0, 0, 0, 0, 1, 0);
        // R6: fault keeps upper on
        repeat (3) step(3'b010, 0, 1, 1, 0, 1, 0);
        // R7: limit flag held until a period start
        step(3'b010, 0, 1, 0, 1, 1, 0);
        repeat (3) step(3'b010, 0, 1, 0, 0, 1, 0);
        step(3'b010, 0, 1, 0, 1, 1, 1);
        step(3'b010, 0, 1, 0, 0, 1, 1);
        repeat (2) step(3'b010, 0, 1, 0, 0, 1, 0);
        // R8: duty low, upper stays on
        repeat (3) step(3'b010, 0, 1, 0, 0, 0, 0);

        // random phase
        idx = 0; hold = 0; ph = 0; d = 0;
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] h;
            if (hold == 0) begin
                idx  = (idx + 1) % 6;
                hold = 3 + int'(dead_len) + ($urandom % 6);
                if ($urandom % 50 == 0) d = ~d;
                if ($urandom % 40 == 0) dead_len = DT_W'($urandom % 6);
            end
            hold--;
            h = d ? ~fwd_seq[idx] : fwd_seq[idx];
            if ($urandom % 30 == 0) h = 3'($urandom);
            ph = (ph + 1) % 8;
            step(h, d, ($urandom % 25) != 0, ($urandom % 40) == 0,
                 ($urandom % 25) == 0, ph < 5, ph == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule